// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a tiny multi-cycle processor with exactly one instruction, so it has no opcode decoding. An instruction is three consecutive memory words: a first data address A, a second data address B and a branch target C. The core reads the three words, then reads both data words. It writes `mem[B] - mem[A]` back to address B. If that difference is negative it jumps to C; otherwise it continues with the next three-word instruction. Any program is built from this single step, with memory used both as program store and as data.

Every access goes through one request channel to a single-port synchronous memory. The request channel uses valid/ready. A request is accepted on a rising edge where `mem_req_valid` and `mem_req_ready` are both high. While valid is high and ready is low, the core holds address, write flag and write data unchanged. The memory may keep ready low for any number of cycles.

A read returns its word on `mem_rsp_rdata` with `mem_rsp_valid` high for one cycle, at some cycle after acceptance. The core always takes the response and applies no back-pressure to it. The core keeps at most one access in flight.

A negative result whose branch target equals the address of the current instruction is a halt. The write still completes, and then `halted` rises and the core stops.

Top module: `subneg_core`

## Requirements
- R1: A synchronous active-high reset sets the instruction address to 0 and clears `halted`. The first request after reset is a read (`mem_req_we` = 0) of address 0.
- R2: For an instruction at address P, the core issues exactly six requests in this order: reads of P, P+1 and P+2 (taken as A, B, C); a read of A; a read of B; and a write to B. Addresses are the low ADDR_W bits of the operand words, and P+1 and P+2 wrap modulo 2^ADDR_W.
- R3: Only the sixth request has `mem_req_we` = 1. Its write data is (word read from B) minus (word read from A), modulo 2^DATA_W.
- R4: If bit DATA_W-1 of the difference is 1, the next instruction starts at C. Otherwise it starts at P+3.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, on the next cycle valid stays high and `mem_req_addr`, `mem_req_we` and `mem_req_wdata` are unchanged.
- R6: After a read is accepted, no new request is raised until its response has arrived.
- R7: A negative difference with C equal to P halts the core. `halted` is high from the cycle after the write is accepted. From then on `mem_req_valid` stays low and `halted` stays high until reset.
- R8: A non-negative difference with C equal to P does not halt. Execution continues at P+3.
- R9: A zero difference, or one that wraps into the positive range (for example 0x8000 - 1 = 0x7FFF), counts as non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_rdata | input | DATA_W | Read data |
| halted | output | 1 | Core has stopped on a halt instruction |

## Verification
Two events fall in the same clock edge: acceptance of the write-back, and the branch decision (next instruction address, or halt). Together they settle both the memory contents and the control flow. The bench provokes this by stalling the write with random ready gaps and by running a directed program that ends in a self-targeting negative step. Programs made of random memory contents add more cases, and each one is compared with a step model kept in the bench. That model checks the write data, then the next fetch address or the halt flag one cycle later. Final memory contents are also checked.

// File: rtl/subneg_pkg.sv
package subneg_pkg;
  typedef enum logic [2:0] {
    ST_FA   = 3'd0,
    ST_FB   = 3'd1,
    ST_FC   = 3'd2,
    ST_RA   = 3'd3,
    ST_RB   = 3'd4,
    ST_WR   = 3'd5,
    ST_HALT = 3'd6
  } step_e;
endpackage

// File: rtl/subneg_alu.sv
module subneg_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output logic              neg
);
  always_comb begin
    diff = minuend - subtrahend;
    neg  = diff[DATA_W-1];
  end
endmodule

// File: rtl/subneg_pc.sv
module subneg_pc #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              take,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc,
  output logic              halt_hit
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(3);

  always_comb halt_hit = take && (target == pc);

  always_ff @(posedge clk) begin
    if (rst)         pc <= '0;
    else if (commit) pc <= take ? target : pc + STEP;
  end

  p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
    commit && !take |=> pc == $past(pc) + STEP);
  p_pc_branch_r4: assert property (@(posedge clk) disable iff (rst)
    commit && take |=> pc == $past(target));
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(pc));
endmodule

// File: rtl/subneg_seq.sv
module subneg_seq
  import subneg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc,
  input  logic              halt_hit,
  input  logic [DATA_W-1:0] diff,
  input  logic              neg,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_we,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] dat_a,
  output logic [DATA_W-1:0] dat_b,
  output logic              commit,
  output logic              take,
  output logic [ADDR_W-1:0] target,
  output logic              halted
);
  step_e             state;
  logic              wait_rsp;
  logic [DATA_W-1:0] op_a, op_b, op_c;
  logic              accept;

  always_comb begin
    unique case (state)
      ST_FA:   req_addr = pc;
      ST_FB:   req_addr = pc + ADDR_W'(1);
      ST_FC:   req_addr = pc + ADDR_W'(2);
      ST_RA:   req_addr = op_a[ADDR_W-1:0];
      default: req_addr = op_b[ADDR_W-1:0];
    endcase
    req_valid = !wait_rsp && (state != ST_HALT);
    req_we    = (state == ST_WR);
    req_wdata = diff;
    accept    = req_valid && req_ready;
    commit    = (state == ST_WR) && accept;
    take      = neg;
    target    = op_c[ADDR_W-1:0];
    halted    = (state == ST_HALT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FA;
      wait_rsp <= 1'b0;
      op_a     <= '0;
      op_b     <= '0;
      op_c     <= '0;
      dat_a    <= '0;
      dat_b    <= '0;
    end else if (state == ST_WR) begin
      if (accept) state <= halt_hit ? ST_HALT : ST_FA;
    end else if (state != ST_HALT) begin
      if (!wait_rsp) begin
        if (accept) wait_rsp <= 1'b1;
      end else if (rsp_valid) begin
        wait_rsp <= 1'b0;
        unique case (state)
          ST_FA:   begin op_a  <= rsp_rdata; state <= ST_FB; end
          ST_FB:   begin op_b  <= rsp_rdata; state <= ST_FC; end
          ST_FC:   begin op_c  <= rsp_rdata; state <= ST_RA; end
          ST_RA:   begin dat_a <= rsp_rdata; state <= ST_RB; end
          default: begin dat_b <= rsp_rdata; state <= ST_WR; end
        endcase
      end
    end
  end

  p_hold_req_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
                               && $stable(req_we) && $stable(req_wdata));
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_we |=> !req_valid);
  p_write_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_we && !halt_hit |=> req_valid && !req_we && req_addr == $past(neg ? target : pc + ADDR_W'(3)));
  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !req_valid);
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> req_valid && !req_we && req_addr == '0 && !halted);
endmodule

// File: rtl/subneg_core.sv
module subneg_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_we,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              halted
);
  logic [ADDR_W-1:0] pc, target;
  logic              halt_hit, commit, take, neg;
  logic [DATA_W-1:0] dat_a, dat_b, diff;

  subneg_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .commit(commit), .take(take),
    .target(target), .pc(pc), .halt_hit(halt_hit)
  );

  subneg_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend(dat_b), .subtrahend(dat_a), .diff(diff), .neg(neg)
  );

  subneg_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .pc(pc), .halt_hit(halt_hit),
    .diff(diff), .neg(neg),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_addr(mem_req_addr), .req_we(mem_req_we), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_rdata(mem_rsp_rdata),
    .dat_a(dat_a), .dat_b(dat_b), .commit(commit), .take(take),
    .target(target), .halted(halted)
  );
endmodule

// File: tb/sim_subneg_core.sv
module sim_subneg_core;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid, req_ready = 1'b0, req_we, rsp_valid = 1'b0, halted;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata = '0;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  int errors = 0, checks = 0;
  int ready_pct = 70;

  always #(CLK_PERIOD/2) clk = ~clk;

  subneg_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst),
    .mem_req_valid(req_valid), .mem_req_ready(req_ready),
    .mem_req_addr(req_addr), .mem_req_we(req_we), .mem_req_wdata(req_wdata),
    .mem_rsp_valid(rsp_valid), .mem_rsp_rdata(rsp_rdata), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] sub_ref(input logic [DW-1:0] b, input logic [DW-1:0] a);
    return b - a;
  endfunction

  // shadow model state
  logic [AW-1:0] epc, oa, ob, oc;
  logic [DW-1:0] da, db;
  int k;
  bit pend, pend_we, chk_halt, exp_halt, stalled;
  logic [AW-1:0] pend_addr, p_addr;
  logic [DW-1:0] pend_wdata, p_wdata;
  logic p_we;

  always @(negedge clk) begin
    if (rst) begin
      epc = '0; k = 0; pend = 0; chk_halt = 0; exp_halt = 0; stalled = 0;
      rsp_valid = 1'b0; req_ready = 1'b0;
    end else begin
      rsp_valid = 1'b0;
      if (pend) begin
        if (pend_we) mem[pend_addr] = pend_wdata;
        else begin rsp_rdata = mem[pend_addr]; rsp_valid = 1'b1; end
        pend = 0;
      end
      if (chk_halt) begin
        chk(halted == exp_halt, exp_halt ? "R7 halt after self-branch" : "R8 no halt", 32'(halted), 32'(exp_halt));
        chk_halt = 0;
      end
      if (halted) chk(!req_valid, "R7 quiet after halt", 32'(req_valid), 0);
      if (rsp_valid) chk(!req_valid, "R6 request while read pending", 32'(req_valid), 0);
      if (stalled) begin
        chk(req_valid && req_addr == p_addr && req_we == p_we && req_wdata == p_wdata,
            "R5 stall hold", {req_valid, 7'd0, req_addr, req_wdata}, {1'b1, 7'd0, p_addr, p_wdata});
      end
      req_ready = ($urandom_range(0, 99) < ready_pct);
      stalled = req_valid && !req_ready;
      p_addr = req_addr; p_we = req_we; p_wdata = req_wdata;
      if (req_valid && req_ready) begin
        logic [DW-1:0] v;
        v = mem[req_addr];
        pend = 1; pend_we = req_we; pend_addr = req_addr; pend_wdata = req_wdata;
        case (k)
          0: begin chk(req_addr == epc && !req_we, "R2 fetch A", 32'(req_addr), 32'(epc)); oa = v[AW-1:0]; end
          1: begin chk(req_addr == AW'(epc + 1) && !req_we, "R2 fetch B", 32'(req_addr), 32'(AW'(epc + 1))); ob = v[AW-1:0]; end
          2: begin chk(req_addr == AW'(epc + 2) && !req_we, "R2 fetch C", 32'(req_addr), 32'(AW'(epc + 2))); oc = v[AW-1:0]; end
          3: begin chk(req_addr == oa && !req_we, "R2 read A", 32'(req_addr), 32'(oa)); da = v; end
          4: begin chk(req_addr == ob && !req_we, "R2 read B", 32'(req_addr), 32'(ob)); db = v; end
          default: begin
            logic [DW-1:0] r;
            r = sub_ref(db, da);
            chk(req_addr == ob && req_we, "R3 write target", {req_we, 23'd0, req_addr}, {1'b1, 23'd0, ob});
            chk(req_wdata == r, "R3 write data", 32'(req_wdata), 32'(r));
            exp_halt = r[DW-1] && (oc == epc);
            chk_halt = 1;
            epc = r[DW-1] ? oc : AW'(epc + 3); // R4 R9
          end
        endcase
        k = (k == 5) ? 0 : k + 1;
        if (!req_we && k == 0) chk(0, "R3 write flag", 0, 1);
      end else if (req_valid && req_we && k != 5) begin
        chk(0, "R3 write flag early", 1, 0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input int a, input logic [DW-1:0] v);
    mem[a] = v;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    // directed program
    put(0, 40);  put(1, 41);  put(2, 6);    // 3-5 = -2 -> branch to 6 (R4)
    put(6, 42);  put(7, 43);  put(8, 6);    // 7-0 nonneg, C==P -> 9 (R8)
    put(9, 44);  put(10, 44); put(11, 30);  // x-x = 0 -> 12 (R9)
    put(12, 45); put(13, 47); put(14, 20);  // 0x8000-1 = 0x7FFF -> 15 (R9)
    put(15, 45); put(16, 46); put(17, 15);  // 0-1 neg, C==P -> halt (R7)
    put(40, 5); put(41, 3); put(42, 0); put(43, 7); put(44, 16'h1234);
    put(45, 1); put(46, 0); put(47, 16'h8000);
    ready_pct = 50;
    do_reset();
    #1;
    chk(req_valid && !req_we && req_addr == 0 && !halted, "R1 reset state",
        {req_valid, req_we, halted, 21'd0, req_addr}, 32'h8000_0000);
    for (int c = 0; c < 400 && !halted; c++) @(negedge clk);
    repeat (20) @(negedge clk);
    #1;
    chk(halted, "R7 directed halt", 32'(halted), 1);
    chk(mem[41] == 16'hFFFE, "R4 negative result stored", 32'(mem[41]), 32'hFFFE);
    chk(mem[43] == 16'h0007, "R8 nonneg self-target result", 32'(mem[43]), 7);
    chk(mem[44] == 16'h0000, "R9 zero result", 32'(mem[44]), 0);
    chk(mem[47] == 16'h7FFF, "R9 wrap to positive", 32'(mem[47]), 32'h7FFF);
    chk(mem[46] == 16'hFFFF, "R7 final write done", 32'(mem[46]), 32'hFFFF);
    chk(mem[30] == 16'h0000, "R4 untaken target untouched", 32'(mem[30]), 0);
    // random programs
    for (int ep = 0; ep < 24; ep++) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = DW'($urandom);
      if (ep % 4 == 0) begin // force an early self-targeting negative step
        put(0, 100); put(1, 101); put(2, 0); put(100, 16'h0001); put(101, 16'h0000);
      end
      ready_pct = 30 + (ep % 3) * 30;
      do_reset();
      #1;
      chk(req_valid && req_addr == 0 && !req_we && !halted, "R1 reset state", 32'(req_addr), 0);
      for (int c = 0; c < 600 && !halted; c++) @(negedge clk);
      repeat (4) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule